// File: doc/BRIEF.md
# Sum-of-Products Output Macrocell

This cell terminates one output of a small programmable logic array. A vector of product-term results arrives from the AND plane, and the cell ORs it into a single sum. A configuration bit can invert that sum. The inverted or plain value then either goes straight to the pin or is first captured in a D flip-flop.

The pin is modelled as three split signals: a drive value, a drive enable and the resolved pin level read back. The cell also returns one feedback bit to the array. In registered mode that bit carries the flip-flop state, so several cells together can form a synchronous state machine. In the other modes it carries the pin level, so a pin set up as an input can still feed the array.

Configuration arrives on static input ports. Each instance picks its own product-term count. One asynchronous reset clears the flip-flop of every cell at the same moment.

Top module: `sop_macrocell`

## Requirements
- R1: The sum is the OR of all `N_TERMS` product-term inputs. `N_TERMS` is a parameter limited to 8..16, and a value outside that range stops elaboration. The lowest term, the highest term, all terms and no term are each handled correctly.
- R2: When `cfg_invert_i`=1, the value presented in either output mode is the complement of the sum. When `cfg_invert_i`=0, it is the sum unchanged.
- R3: In combinational mode (`cfg_mode_i`=2'b01), `pad_o` equals sum XOR `cfg_invert_i` in the same cycle, with no clock edge needed.
- R4: On every rising clock edge while reset is released, the flip-flop captures sum XOR `cfg_invert_i`. Inversion happens before the register. In registered mode (`cfg_mode_i`=2'b10), `pad_o` shows the flip-flop output.
- R5: In input mode (`cfg_mode_i`=2'b00, and also 2'b11), `pad_en_o` is 0 whatever the output-enable term is.
- R6: In combinational and registered modes, `pad_en_o` equals `oe_term_i`.
- R7: In registered mode, `fb_o` is the flip-flop output, even when the driver is disabled and the pin is held at another level.
- R8: In input and combinational modes, `fb_o` equals `pad_i`.
- R9: When `rst_n`=0, the flip-flop clears at once, without waiting for a clock edge. It stays cleared across rising clock edges for as long as reset is held. While cleared in registered mode, `pad_o` and `fb_o` read 0 whatever the polarity setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock, rising edge |
| rst_n | input | 1 | Global asynchronous reset, active low |
| pterm_i | input | N_TERMS | Product-term results from the AND plane |
| oe_term_i | input | 1 | Output-enable product term |
| cfg_mode_i | input | 2 | 00/11 input, 01 combinational, 10 registered |
| cfg_invert_i | input | 1 | 1 inverts the sum |
| pad_i | input | 1 | Resolved pin level |
| pad_o | output | 1 | Pin drive value |
| pad_en_o | output | 1 | Pin driver enable |
| fb_o | output | 1 | Feedback bit to the AND plane |

## Verification
The assertions assume that the configuration inputs hold steady across the cycle in which a registered result is compared. They also assume that `pad_i` follows `pad_o` whenever the driver is enabled, as a real pin would. The bench changes the configuration only at the falling clock edge. It derives `pad_i` from `pad_en_o` and `pad_o`, and uses an independent external level only when the driver is off. The register check is guarded by an antecedent that requires registered mode on two consecutive edges, so mode changes between steps cannot trigger false failures.

// File: rtl/sop_pkg.sv
package sop_pkg;

    typedef enum logic [1:0] {
        MC_INPUT   = 2'b00,
        MC_COMB    = 2'b01,
        MC_REG     = 2'b10,
        MC_INPUT_B = 2'b11
    } mc_mode_e;

    typedef struct packed {
        logic q;
    } mc_state_t;

    localparam int unsigned OR_GROUP = 4;

endpackage

// File: rtl/sop_or_plane.sv
module sop_or_plane
    import sop_pkg::*;
#(
    parameter int unsigned N_TERMS = 8
) (
    input  logic [N_TERMS-1:0] pterm_i,
    input  logic               invert_i,
    output logic               sum_o,
    output logic               pol_o
);

    localparam int unsigned N_GROUPS = (N_TERMS + OR_GROUP - 1) / OR_GROUP;

    logic [N_GROUPS-1:0] grp_or;

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        localparam int unsigned LO = g * OR_GROUP;
        localparam int unsigned HI = ((LO + OR_GROUP - 1) < N_TERMS) ?
                                     (LO + OR_GROUP - 1) : (N_TERMS - 1);
        assign grp_or[g] = |pterm_i[HI:LO];
    end

    always_comb begin
        sum_o = |grp_or;
        pol_o = sum_o ^ invert_i;
    end

endmodule

// File: rtl/sop_state_reg.sv
module sop_state_reg
    import sop_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pol_i,
    output logic q_o
);

    mc_state_t state_d, state_q;

    always_comb begin
        state_d   = state_q;
        state_d.q = pol_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign q_o = state_q.q;

endmodule

// File: rtl/sop_pin_ctl.sv
module sop_pin_ctl
    import sop_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       pol_i,
    input  logic       q_i,
    input  logic       oe_term_i,
    input  logic       pad_i,
    output logic       pad_o,
    output logic       pad_en_o,
    output logic       fb_o
);

    mc_mode_e mode;

    always_comb begin
        mode     = mc_mode_e'(mode_i);
        pad_o    = pol_i;
        pad_en_o = 1'b0;
        fb_o     = pad_i;
        case (mode)
            MC_COMB: begin
                pad_o    = pol_i;
                pad_en_o = oe_term_i;
                fb_o     = pad_i;
            end
            MC_REG: begin
                pad_o    = q_i;
                pad_en_o = oe_term_i;
                fb_o     = q_i;
            end
            default: begin
                pad_o    = pol_i;
                pad_en_o = 1'b0;
                fb_o     = pad_i;
            end
        endcase
    end

endmodule

// File: rtl/sop_macrocell.sv
module sop_macrocell
    import sop_pkg::*;
#(
    parameter int unsigned N_TERMS = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_TERMS-1:0] pterm_i,
    input  logic               oe_term_i,
    input  logic [1:0]         cfg_mode_i,
    input  logic               cfg_invert_i,
    input  logic               pad_i,
    output logic               pad_o,
    output logic               pad_en_o,
    output logic               fb_o
);

    if (N_TERMS < 8 || N_TERMS > 16) begin : g_bad_terms
        $error("sop_macrocell: N_TERMS must lie in 8..16");
    end

    logic sum;
    logic pol;
    logic q;

    sop_or_plane #(.N_TERMS(N_TERMS)) u_or (
        .pterm_i  (pterm_i),
        .invert_i (cfg_invert_i),
        .sum_o    (sum),
        .pol_o    (pol)
    );

    sop_state_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .pol_i (pol),
        .q_o   (q)
    );

    sop_pin_ctl u_pin (
        .mode_i    (cfg_mode_i),
        .pol_i     (pol),
        .q_i       (q),
        .oe_term_i (oe_term_i),
        .pad_i     (pad_i),
        .pad_o     (pad_o),
        .pad_en_o  (pad_en_o),
        .fb_o      (fb_o)
    );

    logic unused_sum;
    assign unused_sum = sum;

endmodule

// File: rtl/sop_macrocell_chk.sv
module sop_macrocell_chk #(
    parameter int unsigned N_TERMS = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_TERMS-1:0] pterm_i,
    input logic               oe_term_i,
    input logic [1:0]         cfg_mode_i,
    input logic               cfg_invert_i,
    input logic               pad_i,
    input logic               pad_o,
    input logic               pad_en_o,
    input logic               fb_o
);

    // R1, R2, R3: combinational pin value follows OR-then-polarity
    a_r3_comb_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_i == 2'b01) |-> (pad_o == ((|pterm_i) ^ cfg_invert_i)));

    // R4: registered pin shows last edge's polarised sum
    a_r4_reg_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_i == 2'b10) ##1 (cfg_mode_i == 2'b10)
        |-> (pad_o == $past((|pterm_i) ^ cfg_invert_i)));

    // R5: input mode never drives
    a_r5_input_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_i == 2'b00 || cfg_mode_i == 2'b11) |-> !pad_en_o);

    // R6: output modes follow the enable term
    a_r6_oe_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_i == 2'b01 || cfg_mode_i == 2'b10) |-> (pad_en_o == oe_term_i));

    // R7: registered feedback equals registered pin value
    a_r7_reg_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_i == 2'b10) |-> (fb_o == pad_o));

    // R8: non-registered feedback is the pin level
    a_r8_pin_fb: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode_i != 2'b10) |-> (fb_o == pad_i));

    // R9: held reset keeps registered outputs at zero
    a_r9_reset_clear: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n) && cfg_mode_i == 2'b10) |-> (!pad_o && !fb_o));

endmodule

bind sop_macrocell sop_macrocell_chk #(.N_TERMS(N_TERMS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pterm_i      (pterm_i),
    .oe_term_i    (oe_term_i),
    .cfg_mode_i   (cfg_mode_i),
    .cfg_invert_i (cfg_invert_i),
    .pad_i        (pad_i),
    .pad_o        (pad_o),
    .pad_en_o     (pad_en_o),
    .fb_o         (fb_o)
);

// File: tb/sim_sop_macrocell.sv
module sim_sop_macrocell;

    localparam int unsigned NT = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b1;
    logic [NT-1:0] pterm = '0;
    logic          oe_term = 1'b0;
    logic [1:0]    mode = 2'b10;
    logic          inv = 1'b0;
    logic          ext_level = 1'b0;
    logic          pad_i;
    logic          pad_o;
    logic          pad_en_o;
    logic          fb_o;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    logic        mq = 1'b0;

    always #10 clk = ~clk;

    assign pad_i = pad_en_o ? pad_o : ext_level;

    sop_macrocell #(.N_TERMS(NT)) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .pterm_i      (pterm),
        .oe_term_i    (oe_term),
        .cfg_mode_i   (mode),
        .cfg_invert_i (inv),
        .pad_i        (pad_i),
        .pad_o        (pad_o),
        .pad_en_o     (pad_en_o),
        .fb_o         (fb_o)
    );

    function automatic logic f_pol(logic [NT-1:0] pt, logic iv);
        return (|pt) ^ iv;
    endfunction

    function automatic logic f_en(logic [1:0] md, logic oe);
        return (md == 2'b01 || md == 2'b10) ? oe : 1'b0;
    endfunction

    function automatic logic f_pad(logic [1:0] md, logic [NT-1:0] pt, logic iv, logic q);
        return (md == 2'b10) ? q : f_pol(pt, iv);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0b expected=%0b (mode=%0b inv=%0b)", tag, act, exp, mode, inv);
        end
    endtask

    task automatic check_all();
        logic ep, ee, pin, ef;
        ep  = f_pad(mode, pterm, inv, mq);
        ee  = f_en(mode, oe_term);
        pin = ee ? ep : ext_level;
        ef  = (mode == 2'b10) ? mq : pin;
        if (mode == 2'b10) chk("R4 pad_o registered", pad_o, ep);
        else if (mode == 2'b01) chk("R3/R2/R1 pad_o combinational", pad_o, ep);
        if (mode == 2'b01 || mode == 2'b10) chk("R6 pad_en_o", pad_en_o, ee);
        else chk("R5 pad_en_o input", pad_en_o, ee);
        if (mode == 2'b10) chk("R7 fb_o registered", fb_o, ef);
        else chk("R8 fb_o pin", fb_o, ef);
    endtask

    task automatic step(logic [NT-1:0] pt, logic oe, logic [1:0] md, logic iv, logic ext);
        @(negedge clk);
        pterm = pt; oe_term = oe; mode = md; inv = iv; ext_level = ext;
        #1 check_all();
        @(posedge clk);
        mq = rst_n ? f_pol(pterm, inv) : 1'b0;
        #1 check_all();
    endtask

    initial begin : watchdog
        #3000000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin : main
        #5 rst_n = 1'b0;
        #1;
        mq = 1'b0;
        chk("R9 reset pad_o", pad_o, 1'b0);
        chk("R9 reset fb_o", fb_o, 1'b0);
        repeat (2) @(posedge clk);
        #1 chk("R9 reset held", pad_o, 1'b0);
        @(negedge clk) rst_n = 1'b1;

        // R1 corner terms, both polarities, combinational and registered
        for (int p = 0; p < 2; p++) begin
            for (int m = 1; m < 3; m++) begin
                step('0, 1'b1, 2'(m), 1'(p), 1'b0);
                step({{(NT-1){1'b0}}, 1'b1}, 1'b1, 2'(m), 1'(p), 1'b0);
                step({1'b1, {(NT-1){1'b0}}}, 1'b1, 2'(m), 1'(p), 1'b0);
                step('1, 1'b1, 2'(m), 1'(p), 1'b0);
            end
        end

        // R5/R8 input mode, enable term high, pin driven externally
        step('1, 1'b1, 2'b00, 1'b0, 1'b0);
        step('0, 1'b1, 2'b11, 1'b1, 1'b1);
        // R7 registered, driver off, pin held opposite
        step('1, 1'b0, 2'b10, 1'b0, 1'b0);
        step('1, 1'b0, 2'b10, 1'b0, 1'b0);

        // random sweep over every mode and polarity
        void'($urandom(32'h5A17));
        for (int i = 0; i < 400; i++) begin
            logic [NT-1:0] pt;
            pt = NT'($urandom);
            if ($urandom % 4 == 0) pt = '0;
            step(pt, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
        end

        // R9 asynchronous clear mid-cycle with q=1, priority over clock
        step('1, 1'b1, 2'b10, 1'b0, 1'b0);
        step('1, 1'b1, 2'b10, 1'b0, 1'b0);
        @(negedge clk);
        #3 rst_n = 1'b0;
        mq = 1'b0;
        #1 chk("R9 async clear pad_o", pad_o, 1'b0);
        chk("R9 async clear fb_o", fb_o, 1'b0);
        @(posedge clk);
        #1 chk("R9 clock ignored in reset", pad_o, 1'b0);
        inv = 1'b1;
        #1 chk("R9 clear independent of polarity", fb_o, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        step('0, 1'b1, 2'b10, 1'b1, 1'b0);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule